// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block decides, one clock at a time, whether the input power switch of a battery charging path may conduct. Its inputs are already-digitised comparator flags: supply present, input over-voltage, output over-current, battery over-voltage and over-temperature. There is also an active-high disable request. It drives a switch-on level and an active-low fault indication.

All intervals are counted in ticks. A tick is one pulse of an internal prescaler every `TICK_DIV` clocks; at `TICK_DIV = 1` every clock is a tick.

The controller is a state machine with eight states:

| State | Meaning |
|---|---|
| `ST_OFF` | Idle: disabled or no supply |
| `ST_BLANK` | Power-up blanking |
| `ST_ON` | Switch conducting |
| `ST_OVP_OFF` | Input over-voltage hold and recovery |
| `ST_OCP_OFF` | Over-current recovery |
| `ST_BAT_OFF` | Battery over-voltage hold |
| `ST_HOT` | Thermal hold |
| `ST_LATCH` | Permanent lock-out |

Transitions:

- **Leaving idle.**
  - Any state goes to `ST_OFF` whenever the supply flag is low or disable is high.
  - `ST_OFF` goes to `ST_BLANK` once enabled.
  - `ST_BLANK` goes to `ST_ON` after `T_POWERUP` ticks.
- **Input over-voltage.**
  - It preempts to `ST_OVP_OFF` from `ST_BLANK`, `ST_ON`, `ST_OCP_OFF`, `ST_BAT_OFF` and `ST_HOT`.
  - `ST_OVP_OFF` returns to `ST_ON` after `T_OVP_REC` consecutive ticks with the flag low.
- **From `ST_ON`.**
  - It goes to `ST_HOT` when hot.
  - It goes to `ST_OCP_OFF` after an over-current trip.
  - It goes to `ST_BAT_OFF` after a battery trip.
  - It goes to `ST_LATCH` when a trip is the last one allowed.
- **Returning to `ST_ON`.**
  - `ST_OCP_OFF` returns after `T_OCP_REC` ticks.
  - `ST_BAT_OFF` returns when the battery flag drops.
  - `ST_HOT` returns when the hot flag drops.
- **Lock-out.** `ST_LATCH` is left only through `ST_OFF`, which also clears the trip counter.

Top module: `chg_prot_seq`

## Requirements
- R1: After reset, and one clock after disable is sampled high or the supply flag is sampled low, `sw_on` is 0 and `fault_n` is 1.
- R2: When the supply flag is high and disable is low starting from `ST_OFF`, `sw_on` rises exactly `T_POWERUP`+1 clocks later (tick every clock).
- R3: An input over-voltage flag sampled high in any running state drives `sw_on` to 0 and `fault_n` to 0 on the next clock, with no blanking.
- R4: After input over-voltage, the switch turns on only after `T_OVP_REC` consecutive clocks with the flag low. A renewed flag restarts that count.
- R5: An over-current flag trips the switch off only when sampled high on `T_OCP_BLANK` consecutive clocks. A shorter pulse leaves `sw_on` at 1 and is not counted.
- R6: After an over-current trip the switch turns back on `T_OCP_REC` clocks later.
- R7: A battery over-voltage flag high for `T_BAT_BLANK` consecutive clocks turns the switch off. The switch turns back on one clock after the flag is sampled low.
- R8: Over-current and battery trips share one counter. The `LATCH_COUNT`-th trip (16 by default) holds `sw_on` at 0 and `fault_n` at 0 until cleared, whatever the fault flags do.
- R9: A disable pulse, or a supply drop, clears the counter and the lock-out, after which power-up blanking runs again.
- R10: Over-temperature turns the switch off on the next clock and back on one clock after the flag drops. `fault_n` stays 1 throughout.
- R11: `fault_n` is 0 in `ST_OVP_OFF`, `ST_OCP_OFF`, `ST_BAT_OFF` and `ST_LATCH`, and `sw_on` is never 1 while `fault_n` is 0.
- R12: In `ST_ON` the priority is input over-voltage, then over-temperature, then over-current, then battery over-voltage. Only one trip is counted per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| sup_ok | input | 1 | Supply above power-on level |
| dis | input | 1 | Active-high disable request |
| in_ovp | input | 1 | Input over-voltage flag |
| out_ocp | input | 1 | Output over-current flag |
| bat_ovp | input | 1 | Battery over-voltage flag |
| hot | input | 1 | Over-temperature flag |
| sw_on | output | 1 | Switch enable |
| fault_n | output | 1 | Active-low fault indication |

## Verification
A wrong state register shows at the ports within one clock, because both outputs decode the state directly. A stray move into `ST_HOT` instead of `ST_OVP_OFF`, for example, leaves `fault_n` high on the very next sample. A wrong recovery or blanking count shifts the rising or falling edge of `sw_on` by whole clocks, and this is caught by sampling exactly on and one clock before the computed edge. A wrong trip count stays hidden until the lock-out boundary. There the switch either recovers after the sixteenth trip or locks out early, which an exact trip tally in the stimulus exposes.

// File: rtl/chg_prot_pkg.sv
package chg_prot_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BLANK,
        ST_ON,
        ST_OVP_OFF,
        ST_OCP_OFF,
        ST_BAT_OFF,
        ST_HOT,
        ST_LATCH
    } prot_state_t;

endpackage

// File: rtl/chg_tick_gen.sv
module chg_tick_gen #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/chg_blank_filt.sv
module chg_blank_filt #(
    parameter int unsigned LEN = 176
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic flag,
    output logic hit
);
    localparam int unsigned W = $clog2(LEN + 1);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;

    // persistence counter: any low sample or leaving the armed state restarts it
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || !flag)
            cnt <= '0;
        else if (tick && (cnt != LAST))
            cnt <= cnt + 1'b1;
    end

    assign hit = run && flag && tick && (cnt == LAST);
endmodule

// File: rtl/chg_trip_cnt.sv
module chg_trip_cnt #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic          last,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != CW'(LIMIT)))
            count <= count + 1'b1;
    end

    assign last = (count == CW'(LIMIT - 1));
endmodule

// File: rtl/chg_prot_seq.sv
module chg_prot_seq #(
    parameter int unsigned TICK_DIV    = 100,
    parameter int unsigned T_POWERUP   = 8000,
    parameter int unsigned T_OVP_REC   = 8000,
    parameter int unsigned T_OCP_BLANK = 176,
    parameter int unsigned T_OCP_REC   = 64000,
    parameter int unsigned T_BAT_BLANK = 176,
    parameter int unsigned LATCH_COUNT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic dis,
    input  logic in_ovp,
    input  logic out_ocp,
    input  logic bat_ovp,
    input  logic hot,
    output logic sw_on,
    output logic fault_n
);
    import chg_prot_pkg::*;

    localparam int unsigned MAX_A   = (T_POWERUP > T_OVP_REC) ? T_POWERUP : T_OVP_REC;
    localparam int unsigned TMR_MAX = (MAX_A > T_OCP_REC) ? MAX_A : T_OCP_REC;
    localparam int unsigned TW      = $clog2(TMR_MAX + 1);
    localparam int unsigned CW      = $clog2(LATCH_COUNT + 1);
    localparam logic [TW-1:0] PU_LAST  = TW'(T_POWERUP - 1);
    localparam logic [TW-1:0] OVP_LAST = TW'(T_OVP_REC - 1);
    localparam logic [TW-1:0] OCP_LAST = TW'(T_OCP_REC - 1);

    prot_state_t   state, nxt;
    logic          tick;
    logic          enabled;
    logic          armed;
    logic          ocp_hit, bat_hit;
    logic          trip_inc, trip_last;
    logic [CW-1:0] trip_cnt;
    logic [TW-1:0] tmr;
    logic          tmr_clr;
    logic          pu_done, ovp_done, ocp_done;

    assign enabled = sup_ok && !dis;
    assign armed   = (state == ST_ON);

    chg_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    chg_blank_filt #(.LEN(T_OCP_BLANK)) u_ocp_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (armed),
        .flag  (out_ocp),
        .hit   (ocp_hit)
    );

    chg_blank_filt #(.LEN(T_BAT_BLANK)) u_bat_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (armed),
        .flag  (bat_ovp),
        .hit   (bat_hit)
    );

    // a counted trip only when no higher-priority condition claims the cycle
    assign trip_inc = armed && enabled && !in_ovp && !hot && (ocp_hit || bat_hit);

    chg_trip_cnt #(.LIMIT(LATCH_COUNT)) u_trips (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_OFF),
        .inc   (trip_inc),
        .last  (trip_last),
        .count (trip_cnt)
    );

    // shared interval timer, restarted on every state change
    assign pu_done  = tick && (tmr == PU_LAST);
    assign ovp_done = tick && (tmr == OVP_LAST);
    assign ocp_done = tick && (tmr == OCP_LAST);
    assign tmr_clr  = (nxt != state) || ((state == ST_OVP_OFF) && in_ovp);

    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr <= '0;
        else if (tmr_clr)
            tmr <= '0;
        else if (tick)
            tmr <= tmr + 1'b1;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!enabled) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     nxt = ST_BLANK;
                ST_BLANK: begin
                    if (in_ovp)       nxt = ST_OVP_OFF;
                    else if (pu_done) nxt = ST_ON;
                end
                ST_ON: begin
                    if (in_ovp)         nxt = ST_OVP_OFF;
                    else if (hot)       nxt = ST_HOT;
                    else if (trip_inc) begin
                        if (trip_last)    nxt = ST_LATCH;
                        else if (ocp_hit) nxt = ST_OCP_OFF;
                        else              nxt = ST_BAT_OFF;
                    end
                end
                ST_OVP_OFF: begin
                    if (!in_ovp && ovp_done) nxt = ST_ON;
                end
                ST_OCP_OFF: begin
                    if (in_ovp)        nxt = ST_OVP_OFF;
                    else if (ocp_done) nxt = ST_ON;
                end
                ST_BAT_OFF: begin
                    if (in_ovp)        nxt = ST_OVP_OFF;
                    else if (!bat_ovp) nxt = ST_ON;
                end
                ST_HOT: begin
                    if (in_ovp)    nxt = ST_OVP_OFF;
                    else if (!hot) nxt = ST_ON;
                end
                ST_LATCH:   nxt = ST_LATCH;
                default:    nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // outputs decoded from the state
    always_comb begin
        sw_on   = 1'b0;
        fault_n = 1'b1;
        unique case (state)
            ST_ON:                                         sw_on = 1'b1;
            ST_OVP_OFF, ST_OCP_OFF, ST_BAT_OFF, ST_LATCH:  fault_n = 1'b0;
            ST_OFF, ST_BLANK, ST_HOT:                      fault_n = 1'b1;
            default:                                       fault_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/chg_prot_seq_chk.sv
module chg_prot_seq_chk
    import chg_prot_pkg::*;
#(
    parameter int unsigned LATCH_COUNT = 16,
    localparam int unsigned CW = $clog2(LATCH_COUNT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sup_ok,
    input logic          dis,
    input logic          in_ovp,
    input logic          bat_ovp,
    input logic          hot,
    input logic          sw_on,
    input logic          fault_n,
    input prot_state_t   st,
    input logic [CW-1:0] trips
);
    assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dis || !sup_ok) |=> (!sw_on && fault_n));

    assert_ovp_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ovp && sw_on) |=> (!sw_on && !fault_n));

    assert_bat_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BAT_OFF && !bat_ovp && !in_ovp && !dis && sup_ok) |=> sw_on);

    assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LATCH && !dis && sup_ok) |=> (st == ST_LATCH && !sw_on && !fault_n));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trips <= CW'(LATCH_COUNT));

    assert_hot_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && sw_on && !in_ovp && !dis && sup_ok) |=> (!sw_on && fault_n));

    assert_fault_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> !sw_on);
endmodule

bind chg_prot_seq chg_prot_seq_chk #(.LATCH_COUNT(LATCH_COUNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sup_ok  (sup_ok),
    .dis     (dis),
    .in_ovp  (in_ovp),
    .bat_ovp (bat_ovp),
    .hot     (hot),
    .sw_on   (sw_on),
    .fault_n (fault_n),
    .st      (state),
    .trips   (trip_cnt)
);

// File: tb/test_chg_prot_seq.sv
module test_chg_prot_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PU   = 20;
    localparam int OVPR = 12;
    localparam int OCPB = 6;
    localparam int OCPR = 15;
    localparam int BATB = 5;
    localparam int LIM  = 16;

    logic clk = 1'b0;
    logic rst_n, sup_ok, dis, in_ovp, out_ocp, bat_ovp, hot;
    logic sw_on, fault_n;
    int   total = 0;
    int   bad   = 0;
    int   trips = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_prot_seq #(
        .TICK_DIV(1), .T_POWERUP(PU), .T_OVP_REC(OVPR), .T_OCP_BLANK(OCPB),
        .T_OCP_REC(OCPR), .T_BAT_BLANK(BATB), .LATCH_COUNT(LIM)
    ) i_chg_prot_seq (
        .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .dis(dis), .in_ovp(in_ovp),
        .out_ocp(out_ocp), .bat_ovp(bat_ovp), .hot(hot), .sw_on(sw_on), .fault_n(fault_n)
    );

    function automatic int trips_to_latch(int so_far);
        return LIM - so_far;
    endfunction

    function automatic int exp_fault_for(int kind);
        // kind 2 is thermal: no fault indication; every other off cause indicates
        return (kind == 2) ? 1 : 0;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic outs(string req, int sw_exp, int f_exp);
        chk(req, "sw_on", int'(sw_on), sw_exp);
        chk(req, "fault_n", int'(fault_n), f_exp);
    endtask

    task automatic power_up();
        sup_ok = 1'b1;
        dis    = 1'b0;
        step(PU);
        outs("R2", 0, 1);
        step(1);
        outs("R2", 1, 1);
    endtask

    task automatic ocp_trip();
        out_ocp = 1'b1;
        step(OCPB - 1);
        outs("R5", 1, 1);
        step(1);
        outs("R5", 0, 0);
        out_ocp = 1'b0;
        step(OCPR - 1);
        outs("R6", 0, 0);
        step(1);
        outs("R6", 1, 1);
        trips++;
    endtask

    task automatic bat_trip(int hold);
        bat_ovp = 1'b1;
        step(BATB - 1);
        outs("R7", 1, 1);
        step(1);
        outs("R7", 0, 0);
        step(hold);
        outs("R7", 0, 0);
        bat_ovp = 1'b0;
        step(1);
        outs("R7", 1, 1);
        trips++;
    endtask

    task automatic latch_out();
        while (trips_to_latch(trips) > 1) ocp_trip();
        out_ocp = 1'b1;
        step(OCPB);
        outs("R8", 0, 0);
        out_ocp = 1'b0;
        step(OCPR + 5);
        outs("R8", 0, 0);
        bat_ovp = 1'b1;
        hot = 1'b1;
        step(BATB + 3);
        bat_ovp = 1'b0;
        hot = 1'b0;
        step(3);
        outs("R8", 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd4242);
        rst_n = 1'b0; sup_ok = 1'b0; dis = 1'b0;
        in_ovp = 1'b0; out_ocp = 1'b0; bat_ovp = 1'b0; hot = 1'b0;
        step(3);
        outs("R1", 0, 1);
        rst_n = 1'b1;
        step(3);
        outs("R1", 0, 1);

        power_up();

        // disable pulse from ST_ON
        dis = 1'b1;
        step(1);
        outs("R1", 0, 1);
        step(2);
        power_up();

        // over-voltage during blanking, then recovery
        sup_ok = 1'b0;
        step(2);
        outs("R1", 0, 1);
        sup_ok = 1'b1;
        step(4);
        in_ovp = 1'b1;
        step(1);
        outs("R3", 0, 0);
        in_ovp = 1'b0;
        step(OVPR - 1);
        outs("R4", 0, 0);
        step(1);
        outs("R4", 1, 1);

        // recovery count restarts on a renewed flag
        in_ovp = 1'b1;
        step(1);
        outs("R3", 0, 0);
        in_ovp = 1'b0;
        step(5);
        in_ovp = 1'b1;
        step(1);
        in_ovp = 1'b0;
        step(OVPR - 1);
        outs("R4", 0, 0);
        step(1);
        outs("R4", 1, 1);

        // priority: over-voltage beats thermal and over-current
        in_ovp = 1'b1; hot = 1'b1; out_ocp = 1'b1;
        step(1);
        outs("R12", 0, 0);
        in_ovp = 1'b0; hot = 1'b0; out_ocp = 1'b0;
        step(OVPR);
        outs("R12", 1, 1);

        // thermal beats over-current; over-current is not blanked while off
        hot = 1'b1; out_ocp = 1'b1;
        step(1);
        outs("R12", 0, 1);
        step(OCPB + 4);
        outs("R12", 0, 1);
        hot = 1'b0; out_ocp = 1'b0;
        step(1);
        outs("R10", 1, 1);

        // thermal pulsing
        hot = 1'b1;
        step(1);
        outs("R10", 0, 1);
        hot = 1'b0;
        step(1);
        outs("R10", 1, 1);

        // longest glitch that must not trip
        out_ocp = 1'b1;
        step(OCPB - 1);
        out_ocp = 1'b0;
        outs("R5", 1, 1);
        step(OCPB + 2);
        outs("R5", 1, 1);

        ocp_trip();

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            int kind;
            int len;
            kind = int'($urandom % 4);
            if (kind == 3 && trips >= 10) kind = 0;
            unique case (kind)
                0: begin
                    len = 1 + int'($urandom % (OCPB - 1));
                    out_ocp = 1'b1;
                    step(len);
                    out_ocp = 1'b0;
                    outs("R5", 1, 1);
                    step(1);
                end
                1: begin
                    len = 1 + int'($urandom % 5);
                    in_ovp = 1'b1;
                    step(1);
                    outs("R3", 0, exp_fault_for(kind));
                    step(len - 1);
                    in_ovp = 1'b0;
                    step(OVPR - 1);
                    outs("R4", 0, exp_fault_for(kind));
                    step(1);
                    outs("R4", 1, 1);
                end
                2: begin
                    len = 1 + int'($urandom % 6);
                    hot = 1'b1;
                    step(1);
                    outs("R10", 0, exp_fault_for(kind));
                    step(len - 1);
                    hot = 1'b0;
                    step(1);
                    outs("R10", 1, 1);
                end
                default: begin
                    bat_trip(int'($urandom % 4));
                end
            endcase
        end

        // exhaust the shared counter: battery and over-current trips both count
        latch_out();

        // clear by disable pulse, then one trip must recover
        dis = 1'b1;
        step(2);
        outs("R9", 0, 1);
        trips = 0;
        power_up();
        ocp_trip();

        // lock out again and clear by supply drop
        latch_out();
        sup_ok = 1'b0;
        step(2);
        outs("R9", 0, 1);
        trips = 0;
        power_up();
        bat_trip(2);

        finish_run();
    end
endmodule